// File: doc/BRIEF.md
# Bitwise Logic Unit with Status Flags

This block is the logic slice of an integer execution stage. It takes two 32-bit operands, an operation code and an operand-size select, and produces the bitwise result together with a new set of status flags. The operations are AND, OR, XOR, a one-operand complement, and a compare-only AND that updates the flags but does not write its destination. Only the low 8, 16 or 32 bits take part, depending on the size select, and the bits above the selected size are returned as zero.

The block is purely combinational and holds no state. The surrounding pipeline supplies the current flag values. The block either returns those values unchanged or replaces them, depending on the operation. The destination write-enable tells the register-file write port whether to store the result.

Top module: `lu_logic_unit`

## Requirements
- R1: For AND (op 000), OR (op 001) and XOR (op 010), each result bit below the selected size is that bitwise function of the matching bits of A and B. Every result bit at or above the selected size is 0.
- R2: For the complement operation (op 011), each result bit below the selected size is the inverse of the matching bit of A. B is ignored and the bits above the size are 0.
- R3: The complement operation drives every flag output (CF, OF, ZF, SF, PF, AF) equal to its flag input.
- R4: AND, OR, XOR and compare-only AND (op 100) drive CF and OF to 0 whatever their inputs are.
- R5: For ops 000, 001, 010 and 100, ZF is 1 exactly when the size-limited result is all zeros.
- R6: For ops 000, 001, 010 and 100, SF equals the most significant result bit of the selected size: bit 7, bit 15 or bit 31.
- R7: For ops 000, 001, 010 and 100, PF is 1 exactly when result bits 7..0 hold an even number of ones.
- R8: Compare-only AND (op 100) produces the same result value and flags as AND, with the destination write-enable held at 0. Ops 000 to 011 drive the write-enable to 1.
- R9: AF always equals its input, for every operation.
- R10: Size select 00 is 8 bits and 01 is 16 bits. Both 10 and 11 select 32 bits.
- R11: Op codes 101, 110 and 111 are reserved. They give a zero result and a write-enable of 0, and every flag output equals its input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (destination value) |
| opnd_b | input | 32 | Second operand (source value) |
| op_sel | input | 3 | Operation code |
| size_sel | input | 2 | Operand size select |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| zf_in | input | 1 | Incoming zero flag |
| sf_in | input | 1 | Incoming sign flag |
| pf_in | input | 1 | Incoming parity flag |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| result | output | 32 | Size-limited result |
| dest_we | output | 1 | Destination write-enable |
| cf_out | output | 1 | Updated carry flag |
| of_out | output | 1 | Updated overflow flag |
| zf_out | output | 1 | Updated zero flag |
| sf_out | output | 1 | Updated sign flag |
| pf_out | output | 1 | Updated parity flag |
| af_out | output | 1 | Updated auxiliary-carry flag |

## Verification
No register lies between the inputs and any output, so the result, the write-enable and all six flags are due in the same cycle as the stimulus, with zero cycles of latency. The bench changes the inputs 1 ns after a rising edge and compares every output with its behavioural model at the following falling edge. This gives the logic time to settle and keeps the stimulus clear of the edge. Directed vectors cover the sign bit and parity at each size, all-zero results, the reserved codes and the aliased size select. A long pseudo-random stream follows them.

// File: rtl/lu_pkg.sv
package lu_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_INV  = 3'd3,
        OP_TEST = 3'd4,
        OP_RSV5 = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } lu_op_e;

    typedef enum logic [1:0] {
        SZ_B8     = 2'd0,
        SZ_B16    = 2'd1,
        SZ_B32    = 2'd2,
        SZ_B32ALT = 2'd3
    } lu_size_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic zf;
        logic sf;
        logic pf;
        logic af;
    } lu_flags_t;

    localparam int unsigned PAR_W = 8;

endpackage

// File: rtl/lu_size_mask.sv
module lu_size_mask
    import lu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  lu_size_e            size,
    output logic [DATA_W-1:0]   keep_mask,
    output logic [DATA_W-1:0]   sign_pick
);
    localparam int unsigned CNT_W   = $clog2(DATA_W) + 1;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned HALF_W  = DATA_W / 2;

    logic [CNT_W-1:0] act_w;

    always_comb begin
        unique case (size)
            SZ_B8:   act_w = CNT_W'(BYTE_W);
            SZ_B16:  act_w = CNT_W'(HALF_W);
            default: act_w = CNT_W'(DATA_W);
        endcase
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign keep_mask[g] = (CNT_W'(g) < act_w);
        assign sign_pick[g] = (CNT_W'(g + 1) == act_w);
    end

endmodule

// File: rtl/lu_bitwise.sv
module lu_bitwise
    import lu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  lu_op_e            op,
    input  logic [DATA_W-1:0] keep_mask,
    output logic [DATA_W-1:0] res,
    output logic              wr_en,
    output logic              flag_upd
);
    logic [DATA_W-1:0] raw;

    always_comb begin
        unique case (op)
            OP_AND: begin
                raw = a & b;  wr_en = 1'b1; flag_upd = 1'b1;
            end
            OP_OR: begin
                raw = a | b;  wr_en = 1'b1; flag_upd = 1'b1;
            end
            OP_XOR: begin
                raw = a ^ b;  wr_en = 1'b1; flag_upd = 1'b1;
            end
            OP_INV: begin
                raw = ~a;     wr_en = 1'b1; flag_upd = 1'b0;
            end
            OP_TEST: begin
                raw = a & b;  wr_en = 1'b0; flag_upd = 1'b1;
            end
            default: begin
                raw = '0;     wr_en = 1'b0; flag_upd = 1'b0;
            end
        endcase
        res = raw & keep_mask;
    end

endmodule

// File: rtl/lu_flag_gen.sv
module lu_flag_gen
    import lu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] sign_pick,
    input  logic              flag_upd,
    input  lu_flags_t         flags_in,
    output lu_flags_t         flags_out
);
    lu_flags_t fresh;

    always_comb begin
        fresh.cf = 1'b0;
        fresh.of = 1'b0;
        fresh.zf = ~|res;
        fresh.sf = |(res & sign_pick);
        fresh.pf = ~^res[PAR_W-1:0];
        fresh.af = flags_in.af;
        flags_out = flag_upd ? fresh : flags_in;
    end

endmodule

// File: rtl/lu_logic_unit.sv
module lu_logic_unit
    import lu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [2:0]        op_sel,
    input  logic [1:0]        size_sel,
    input  logic              cf_in,
    input  logic              of_in,
    input  logic              zf_in,
    input  logic              sf_in,
    input  logic              pf_in,
    input  logic              af_in,
    output logic [DATA_W-1:0] result,
    output logic              dest_we,
    output logic              cf_out,
    output logic              of_out,
    output logic              zf_out,
    output logic              sf_out,
    output logic              pf_out,
    output logic              af_out
);
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] sign_pick;
    logic              flag_upd;
    lu_flags_t         flags_in;
    lu_flags_t         flags_out;

    assign flags_in = '{cf: cf_in, of: of_in, zf: zf_in,
                        sf: sf_in, pf: pf_in, af: af_in};

    lu_size_mask #(.DATA_W(DATA_W)) u_mask (
        .size      (lu_size_e'(size_sel)),
        .keep_mask (keep_mask),
        .sign_pick (sign_pick)
    );

    lu_bitwise #(.DATA_W(DATA_W)) u_bw (
        .a         (opnd_a),
        .b         (opnd_b),
        .op        (lu_op_e'(op_sel)),
        .keep_mask (keep_mask),
        .res       (result),
        .wr_en     (dest_we),
        .flag_upd  (flag_upd)
    );

    lu_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .res       (result),
        .sign_pick (sign_pick),
        .flag_upd  (flag_upd),
        .flags_in  (flags_in),
        .flags_out (flags_out)
    );

    assign cf_out = flags_out.cf;
    assign of_out = flags_out.of;
    assign zf_out = flags_out.zf;
    assign sf_out = flags_out.sf;
    assign pf_out = flags_out.pf;
    assign af_out = flags_out.af;

endmodule

// File: rtl/lu_logic_unit_checker.sv
module lu_logic_unit_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [2:0]        op_sel,
    input logic [1:0]        size_sel,
    input logic              cf_in,
    input logic              of_in,
    input logic              zf_in,
    input logic              sf_in,
    input logic              pf_in,
    input logic              af_in,
    input logic [DATA_W-1:0] result,
    input logic              dest_we,
    input logic              cf_out,
    input logic              of_out,
    input logic              zf_out,
    input logic              sf_out,
    input logic              pf_out,
    input logic              af_out
);
    logic              logic_op;
    logic [DATA_W-1:0] a_low;
    int unsigned       top;

    always_comb begin
        logic_op = (op_sel == 3'd0) || (op_sel == 3'd1) ||
                   (op_sel == 3'd2) || (op_sel == 3'd4);
        top = (size_sel == 2'd0) ? 7 : (size_sel == 2'd1) ? (DATA_W/2 - 1) : (DATA_W - 1);
        a_low = opnd_a ^ opnd_b;

        assert_af_pass_R9: assert (af_out == af_in);
        if (op_sel == 3'd3) begin
            assert_inv_keeps_flags_R3: assert (cf_out == cf_in && of_out == of_in &&
                zf_out == zf_in && sf_out == sf_in && pf_out == pf_in);
        end
        if (logic_op) begin
            assert_cf_of_clear_R4: assert (!cf_out && !of_out);
            assert_zero_flag_R5:   assert (zf_out == (result == '0));
            assert_sign_flag_R6:   assert (sf_out == result[top]);
            assert_parity_flag_R7: assert (pf_out == ~^result[7:0]);
        end
        if (op_sel == 3'd4) begin
            assert_test_no_write_R8: assert (!dest_we);
        end
        if (op_sel >= 3'd5) begin
            assert_reserved_quiet_R11: assert (!dest_we && result == '0 &&
                zf_out == zf_in && sf_out == sf_in && a_low == (opnd_a ^ opnd_b));
        end
        if (top < DATA_W - 1) begin
            assert_upper_zero_R1: assert ((result >> (top + 1)) == '0);
        end
    end

endmodule

bind lu_logic_unit lu_logic_unit_checker #(.DATA_W(DATA_W)) u_lu_chk (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .size_sel(size_sel),
    .cf_in(cf_in), .of_in(of_in), .zf_in(zf_in), .sf_in(sf_in),
    .pf_in(pf_in), .af_in(af_in), .result(result), .dest_we(dest_we),
    .cf_out(cf_out), .of_out(of_out), .zf_out(zf_out), .sf_out(sf_out),
    .pf_out(pf_out), .af_out(af_out)
);

// File: tb/lu_logic_unit_bench.sv
`timescale 1ns/1ps
module lu_logic_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  size_sel = '0;
    logic        cf_in = 0, of_in = 0, zf_in = 0, sf_in = 0, pf_in = 0, af_in = 0;
    logic [31:0] result;
    logic        dest_we, cf_out, of_out, zf_out, sf_out, pf_out, af_out;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lu_logic_unit u_lu_logic_unit (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .size_sel(size_sel),
        .cf_in(cf_in), .of_in(of_in), .zf_in(zf_in), .sf_in(sf_in),
        .pf_in(pf_in), .af_in(af_in), .result(result), .dest_we(dest_we),
        .cf_out(cf_out), .of_out(of_out), .zf_out(zf_out), .sf_out(sf_out),
        .pf_out(pf_out), .af_out(af_out)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h (op=%0d size=%0d a=%h b=%h)",
                     tag, act, exp, op_sel, size_sel, opnd_a, opnd_b);
        end
    endtask

    // Behavioural model and comparison, sampled at the falling edge.
    task automatic apply(input int op, input int sz, input logic [31:0] a,
                         input logic [31:0] b, input logic [5:0] fin);
        int          bits;
        longint      mask;
        longint      raw;
        longint      er;
        int          ones;
        bit          we, upd;
        bit          ecf, eof, ezf, esf, epf;
        @(posedge clk);
        #1;
        opnd_a = a; opnd_b = b; op_sel = 3'(op); size_sel = 2'(sz);
        {cf_in, of_in, zf_in, sf_in, pf_in, af_in} = fin;
        bits = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;             // R10
        mask = (64'd1 << bits) - 1;
        case (op)
            0: begin raw = a & b;  we = 1; upd = 1; end
            1: begin raw = a | b;  we = 1; upd = 1; end
            2: begin raw = a ^ b;  we = 1; upd = 1; end
            3: begin raw = ~a;     we = 1; upd = 0; end
            4: begin raw = a & b;  we = 0; upd = 1; end
            default: begin raw = 0; we = 0; upd = 0; end     // R11
        endcase
        er = raw & mask;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(er[i]);
        if (upd) begin
            ecf = 0; eof = 0;                                   // R4
            ezf = (er == 0);                                    // R5
            esf = er[bits-1];                                   // R6
            epf = (ones % 2 == 0);                              // R7
        end else begin
            {ecf, eof, ezf, esf, epf} = fin[5:1];               // R3
        end
        @(negedge clk);
        check((op == 3) ? "R2 result" : (op >= 5) ? "R11 result" : "R1 result",
              longint'(result), er);
        check("R8 dest_we", longint'(dest_we), longint'(we));
        check("R4 cf", longint'(cf_out), longint'(ecf));
        check("R4 of", longint'(of_out), longint'(eof));
        check("R5 zf", longint'(zf_out), longint'(ezf));
        check("R6 sf", longint'(sf_out), longint'(esf));
        check("R7 pf", longint'(pf_out), longint'(epf));
        check("R9 af", longint'(af_out), longint'(fin[0]));
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: all-zero inputs give an AND with zero result.
        @(negedge clk);
        check("R5 idle zf", longint'(zf_out), 1);
        check("R8 idle we", longint'(dest_we), 1);
        check("R1 idle result", longint'(result), 0);

        // R1 masking examples at each size
        apply(0, 2, 32'h4C881D7B, 32'h0000000F, 6'b000000);
        apply(0, 0, 32'hFFFF_FF80, 32'hFFFF_FFFF, 6'b110000);   // R6 byte sign
        apply(1, 1, 32'h1234_0004, 32'h0000_8030, 6'b110001);   // R6 word sign
        apply(2, 2, 32'h8000_0000, 32'h0000_0001, 6'b110000);   // R6 dword sign
        apply(2, 0, 32'h5353_5353, 32'h0000_0020, 6'b000000);
        // R5 zero results
        apply(0, 0, 32'hFFFF_FF00, 32'hFFFF_FFFF, 6'b000000);
        apply(2, 1, 32'hABCD_1234, 32'h0000_1234, 6'b111111);
        // R2 / R3 complement, flags pass through
        apply(3, 0, 32'h0000_00B6, 32'hFFFF_FFFF, 6'b101010);
        apply(3, 2, 32'h0F0F_0F0F, 32'h0, 6'b010101);
        apply(3, 1, 32'hFFFF_FFFF, 32'h0, 6'b111110);
        // R8 compare-only AND
        apply(4, 1, 32'h0000_FA75, 32'h0000_0004, 6'b110000);
        apply(4, 2, 32'h0000_2000, 32'h0000_2000, 6'b000001);
        // R10 aliased size 11
        apply(1, 3, 32'h8000_0000, 32'h0000_0003, 6'b000000);
        // R11 reserved codes
        apply(5, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'b101101);
        apply(6, 0, 32'h1, 32'h2, 6'b010010);
        apply(7, 1, 32'h0, 32'h0, 6'b000000);
        // R7 parity odd/even
        apply(1, 2, 32'h0000_0007, 32'h0, 6'b000000);
        apply(1, 2, 32'hFF00_0003, 32'h0, 6'b000000);

        for (int n = 0; n < 3000; n++) begin
            apply(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                  $urandom, ($urandom_range(0, 3) == 0) ? ~32'h0 : $urandom,
                  6'($urandom));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule